// File: doc/BRIEF.md
# Multi-Line Receive Character Silo

This block is the shared receive queue of an eight-line asynchronous serial controller. Every receiver that finishes a character pushes it here, together with the number of the line it came from and its framing and parity error flags. Software drains the queue by reading one 16-bit receive word, and each read strobe removes the oldest entry. The deserializers and the bus decoding sit outside this block. It only sees a one-cycle push strobe from the receivers and a one-cycle read strobe from the register decoder.

The queue holds 64 entries. A character that arrives while the queue is full and no read takes place is dropped. The drop is not silent: the next character that is stored carries an overrun mark.

The block drives one interrupt request, `irq`, and supports two notification styles:
- **Per-character:** the request follows "queue not empty".
- **Batched (alarm):** the request rises only once 16 characters have been stored since the last read. It stays up until software reads the queue, and the count then starts again from zero.

A software clear input and the synchronous reset both empty the queue. The depth must be a power of two.

Top module: `rx_silo`

## Requirements
- R1: Up to DEPTH (64) characters are held and returned in arrival order, each with the line number and error flags it was pushed with.
- R2: A push while the queue is full and no read is accepted is dropped. The next stored entry has its overrun bit (read word bit 14) set, and only that entry.
- R3: After an accepted read, the read word has the following layout:
  - bit 15 is 1 (data valid)
  - bit 14 is overrun
  - bit 13 is framing error
  - bit 12 is parity error
  - bit 11 is 0
  - bits 10:8 are the line number
  - bits 7:0 are the character
- R4: A read strobe while the queue is empty makes the read word 16'h0000 (data valid clear) on the next cycle.
- R5: `rx_done` is 1 exactly when the queue holds at least one entry, updated on the clock edge that changes the occupancy.
- R6: With `alarm_en` = 0, `irq` one cycle after an edge equals `rx_ie` AND `rx_done`.
- R7: With `alarm_en` = 1 and `rx_ie` = 1, `irq` stays 0 while fewer than 16 characters have been stored since the last read, and rises on the edge that stores the 16th.
- R8: The alarm, once raised, holds until a read strobe. The read drops it and restarts the count of stored characters at zero.
- R9: `soft_clr` or `rst` empties the queue, drops the pending overrun mark and the alarm count, and forces `rd_word`, `rx_done` and `irq` to 0.
- R10: A push and a read in the same cycle leave the occupancy unchanged and keep the order, including when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Software clear, empties the silo |
| push_valid | input | 1 | A receiver delivers a character this cycle |
| push_line | input | 3 | Line number of the delivered character |
| push_char | input | 8 | Received character |
| push_ferr | input | 1 | Framing error on the delivered character |
| push_perr | input | 1 | Parity error on the delivered character |
| rd_strobe | input | 1 | Read of the receive word, pops one entry |
| alarm_en | input | 1 | Selects batched (16-character) notification |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_word | output | 16 | Receive word from the last read |
| rx_done | output | 1 | Silo not empty |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the silo to exactly 64 entries and pushes one more. A design that overwrote the oldest entry, or forgot to tag the next entry, would show a wrong word or a missing bit 14 when the queue is drained.

It issues a push and a read together on a full silo and separately on an empty one. An off-by-one in full or empty handling would either lose that character or return a stale, valid-looking word.

The alarm is taken to 15 characters and then to the 16th. It is then held across idle cycles, dropped by a read, and counted up again from zero. An early, late or self-clearing alarm shows up directly on `irq`.

Soft clear and reset are applied with data still queued, to catch a leftover overrun mark or alarm count.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 3;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] chr;
  } silo_entry_t;

  localparam int ENTRY_W = $bits(silo_entry_t);

  function automatic logic [WORD_W-1:0] to_word(input silo_entry_t e);
    return {1'b1, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.chr};
  endfunction
endpackage

// File: rtl/rx_silo_ram.sv
module rx_silo_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 14,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Synchronous write and read-before-write read port, block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl #(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          ovr_tag,
  output logic          empty,
  output logic          nonempty_n,
  output logic          done_q
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             full;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  // A full silo still accepts a character when the same cycle frees a slot.
  assign push_ok = push && (!full || pop_ok);

  always_comb begin
    cnt_n = cnt_q;
    if (push_ok && !pop_ok) cnt_n = cnt_q + CNT_W'(1);
    else if (pop_ok && !push_ok) cnt_n = cnt_q - CNT_W'(1);
  end
  assign nonempty_n = (cnt_n != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      ovr_tag <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= nonempty_n;
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      if (push_ok)   ovr_tag <= 1'b0;
      else if (push) ovr_tag <= 1'b1;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));

  p_ptr_gap_r1: assert property (@(posedge clk) disable iff (rst)
    AW'(wr_ptr - rd_ptr) == cnt_q[AW-1:0]);

  p_drop_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> ovr_tag);

  p_pair_keeps_count_r10: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
  parameter int ALARM_AT = 16,
  localparam int CW      = $clog2(ALARM_AT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic store,
  input  logic rd,
  output logic flag_n,
  output logic flag_q
);
  logic [CW-1:0] cnt_q, base, cnt_n;

  always_comb begin
    base  = rd ? '0 : cnt_q;
    cnt_n = base;
    if (store && base < CW'(ALARM_AT)) cnt_n = base + CW'(1);
  end
  assign flag_n = (cnt_n >= CW'(ALARM_AT));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  p_alarm_at_threshold_r7: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> (cnt_q == CW'(ALARM_AT)));

  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd) |=> flag_q);

  p_read_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    rd |=> (cnt_q <= CW'(1)));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ALARM_AT = 16,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_clr,
  input  logic              push_valid,
  input  logic [LINE_W-1:0] push_line,
  input  logic [CHAR_W-1:0] push_char,
  input  logic              push_ferr,
  input  logic              push_perr,
  input  logic              rd_strobe,
  input  logic              alarm_en,
  input  logic              rx_ie,
  output logic [WORD_W-1:0] rd_word,
  output logic              rx_done,
  output logic              irq
);
  logic          clr;
  logic          push_ok, pop_ok, ovr_tag, empty, nonempty_n;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          alarm_n, alarm_q;
  logic          valid_q, irq_q;
  silo_entry_t   wr_entry;
  logic [ENTRY_W-1:0] ram_q;

  assign clr = rst || soft_clr;

  assign wr_entry = '{ovr: ovr_tag, ferr: push_ferr, perr: push_perr,
                      line: push_line, chr: push_char};

  rx_silo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(clr), .push(push_valid), .pop(rd_strobe),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .ovr_tag(ovr_tag), .empty(empty), .nonempty_n(nonempty_n), .done_q(rx_done)
  );

  rx_silo_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) u_ram (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_entry),
    .re(pop_ok), .raddr(rd_ptr), .rdata(ram_q)
  );

  rx_silo_alarm #(.ALARM_AT(ALARM_AT)) u_alarm (
    .clk(clk), .rst(clr), .store(push_ok), .rd(rd_strobe),
    .flag_n(alarm_n), .flag_q(alarm_q)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_strobe) valid_q <= pop_ok;
      irq_q <= rx_ie && (alarm_en ? alarm_n : nonempty_n);
    end
  end

  // The RAM output holds a stale entry after an empty read; the valid bit masks it.
  assign rd_word = valid_q ? to_word(silo_entry_t'(ram_q)) : '0;
  assign irq     = irq_q;

  p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && empty) |=> (rd_word == '0));

  p_done_tracks_fill_r5: assert property (@(posedge clk) disable iff (rst)
    rx_done == !empty);

  p_irq_per_char_r6: assert property (@(posedge clk) disable iff (rst)
    (!alarm_en && rx_ie) |=> (irq == rx_done));

  p_irq_alarm_r7: assert property (@(posedge clk) disable iff (rst)
    (alarm_en && !soft_clr) |=> (irq == ($past(rx_ie) && alarm_q)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (!rx_done && !irq && rd_word == '0));
endmodule

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
  localparam int DEPTH = 64;
  localparam int ALARM_AT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_clr = 1'b0;
  logic        push_valid = 1'b0;
  logic [2:0]  push_line = '0;
  logic [7:0]  push_char = '0;
  logic        push_ferr = 1'b0;
  logic        push_perr = 1'b0;
  logic        rd_strobe = 1'b0;
  logic        alarm_en = 1'b0;
  logic        rx_ie = 1'b0;
  logic [15:0] rd_word;
  logic        rx_done;
  logic        irq;

  always #5 clk = ~clk;

  rx_silo u_rx_silo (
    .clk(clk), .rst(rst), .soft_clr(soft_clr), .push_valid(push_valid),
    .push_line(push_line), .push_char(push_char), .push_ferr(push_ferr),
    .push_perr(push_perr), .rd_strobe(rd_strobe), .alarm_en(alarm_en),
    .rx_ie(rx_ie), .rd_word(rd_word), .rx_done(rx_done), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string phase = "R9";

  // Behavioural reference: entry bits {ovr, ferr, perr, line[2:0], char[7:0]}
  logic [13:0] q[$];
  bit          m_ovr = 1'b0;
  int          m_acnt = 0;
  bit          m_alarm = 1'b0;
  logic [15:0] e_word = '0;
  logic        e_done = 1'b0;
  logic        e_irq = 1'b0;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit pop_ok, acc;
    logic [13:0] e;
    if (rst || soft_clr) begin
      q.delete();
      m_ovr = 0; m_acnt = 0; m_alarm = 0;
      e_word = '0; e_done = 0; e_irq = 0;
      return;
    end
    pop_ok = rd_strobe && (q.size() > 0);
    if (rd_strobe) begin
      if (pop_ok) begin
        e = q.pop_front();
        e_word = {1'b1, e[13:11], 1'b0, e[10:0]};
      end else begin
        e_word = '0;
      end
    end
    acc = 0;
    if (push_valid) begin
      if (q.size() < DEPTH) begin
        q.push_back({m_ovr, push_ferr, push_perr, push_line, push_char});
        m_ovr = 0;
        acc = 1;
      end else begin
        m_ovr = 1;
      end
    end
    if (rd_strobe) m_acnt = 0;
    if (acc && m_acnt < ALARM_AT) m_acnt++;
    m_alarm = (m_acnt >= ALARM_AT);
    e_done = (q.size() > 0);
    e_irq = rx_ie && (alarm_en ? m_alarm : e_done);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(phase, "rd_word", rd_word, e_word);
    check(phase, "rx_done", {15'b0, rx_done}, {15'b0, e_done});
    check(phase, "irq", {15'b0, irq}, {15'b0, e_irq});
  endtask

  task automatic push_one(input logic [2:0] ln, input logic [7:0] ch,
                          input logic fe, input logic pe);
    push_valid = 1; push_line = ln; push_char = ch; push_ferr = fe; push_perr = pe;
    cyc();
    push_valid = 0; push_ferr = 0; push_perr = 0;
  endtask

  task automatic pop_one();
    rd_strobe = 1;
    cyc();
    rd_strobe = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    cyc(); cyc();
    rst = 0;
    cyc();
    check("R9", "reset word", rd_word, 16'h0000);
    check("R9", "reset done", {15'b0, rx_done}, 16'h0000);

    // R5/R6: per-character interrupt
    phase = "R6";
    rx_ie = 1;
    push_one(3'd5, 8'hA7, 1'b1, 1'b0);
    check("R5", "done after push", {15'b0, rx_done}, 16'h0001);
    check("R6", "irq after push", {15'b0, irq}, 16'h0001);
    // R3: field layout
    phase = "R3";
    pop_one();
    check("R3", "word fields", rd_word, 16'hA5A7);
    check("R5", "done after drain", {15'b0, rx_done}, 16'h0000);
    // R4: empty read
    phase = "R4";
    pop_one();
    check("R4", "empty read", rd_word, 16'h0000);

    // R1: fill to capacity, in order
    phase = "R1";
    rx_ie = 0;
    for (int i = 0; i < DEPTH; i++)
      push_one(3'(i % 8), 8'(i * 3 + 1), i[0], i[1]);
    // R2: one push too many is dropped
    phase = "R2";
    push_one(3'd6, 8'hEE, 1'b0, 1'b0);
    // R10: push and read together on a full silo
    phase = "R10";
    push_valid = 1; push_line = 3'd7; push_char = 8'h3C; rd_strobe = 1;
    cyc();
    push_valid = 0; rd_strobe = 0;
    check("R10", "oldest out on full pair", rd_word, 16'h8001);
    check("R10", "still full", {15'b0, rx_done}, 16'h0001);
    phase = "R1";
    for (int i = 1; i < DEPTH; i++) pop_one();
    phase = "R2";
    pop_one();
    check("R2", "overrun tagged entry", rd_word, 16'hC73C);
    pop_one();
    check("R4", "empty after drain", rd_word, 16'h0000);

    // R10: push and read together on an empty silo
    phase = "R10";
    push_valid = 1; push_line = 3'd2; push_char = 8'h11; rd_strobe = 1;
    cyc();
    push_valid = 0; rd_strobe = 0;
    check("R10", "empty pair word", rd_word, 16'h0000);
    check("R10", "empty pair stored", {15'b0, rx_done}, 16'h0001);
    pop_one();
    check("R2", "overrun not repeated", rd_word, 16'h8211);

    // R7: alarm threshold
    phase = "R7";
    alarm_en = 1; rx_ie = 1;
    cyc();
    for (int i = 0; i < ALARM_AT - 1; i++) push_one(3'd1, 8'(i), 1'b0, 1'b1);
    check("R7", "no irq at 15", {15'b0, irq}, 16'h0000);
    push_one(3'd1, 8'h0F, 1'b0, 1'b0);
    check("R7", "irq at 16", {15'b0, irq}, 16'h0001);
    // R8: hold, then read re-arms
    phase = "R8";
    repeat (5) cyc();
    check("R8", "alarm held", {15'b0, irq}, 16'h0001);
    pop_one();
    check("R8", "alarm dropped by read", {15'b0, irq}, 16'h0000);
    for (int i = 0; i < ALARM_AT - 1; i++) push_one(3'd4, 8'h40 + 8'(i), 1'b0, 1'b0);
    check("R8", "count restarted", {15'b0, irq}, 16'h0000);
    push_one(3'd4, 8'h5F, 1'b0, 1'b0);
    check("R8", "alarm again", {15'b0, irq}, 16'h0001);

    // R9: software clear with data queued
    phase = "R9";
    soft_clr = 1;
    cyc();
    soft_clr = 0;
    check("R9", "clear done", {15'b0, rx_done}, 16'h0000);
    check("R9", "clear irq", {15'b0, irq}, 16'h0000);
    pop_one();
    check("R9", "clear then read", rd_word, 16'h0000);
    alarm_en = 0;
    for (int i = 0; i < 3; i++) push_one(3'(i), 8'h90 + 8'(i), 1'b1, 1'b1);
    rst = 1;
    cyc();
    rst = 0;
    cyc();
    check("R9", "reset done", {15'b0, rx_done}, 16'h0000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule